// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address by reading a two-level page table from memory. It takes the virtual address and forms the first-level entry address from a root table register. That register holds the page number of the current root table and software rewrites it when the active context changes. Depending on that entry, the walker either finishes at once with a large-page mapping or goes on to read a second-level entry. At the end it hands back a physical page number, three protection and usage bits and a large-page flag, which a translation buffer uses for its refill.

Every page table entry is 32 bits wide. Bit 0 says the page exists, bit 1 marks a first-level entry as a direct large-page mapping, bits 2, 3 and 4 carry read, write and dirty, and bits 31:12 hold a page number. That page number is the next table, the data page, or a disk location when the present bit is clear. If the walker meets a non-present entry at either level it abandons the walk and signals a page fault for the original access, along with the level that failed. Memory is reached through a read port with no back-pressure: the request is a one-cycle pulse and the response comes back some cycles later.

Only one walk is active at a time. A new address is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: walkReady is 1, and memReqValid, doneValid and faultValid are 0.
- R2: On the cycle after a request is accepted, memReqValid pulses for one cycle with memReqAddr = {root page number, 12'b0} + 4 * va[31:22].
- R3: When the first-level response has bit 0 = 1 and bit 1 = 0, the cycle after that response carries a one-cycle request at {entry[31:12], 12'b0} + 4 * va[21:12].
- R4: A first-level response with bit 0 = 1 and bit 1 = 1 ends the walk with no second-level request. donePpn = {entry[31:22], va[21:12]} and doneLarge = 1.
- R5: A present second-level response ends the walk with donePpn = entry[31:12] and doneLarge = 0. Bit 1 of a second-level entry has no effect.
- R6: doneRead, doneWrite and doneDirty equal bits 2, 3 and 4 of the entry that ended the walk.
- R7: A response with bit 0 = 0 at either level ends the walk with a one-cycle faultValid, no doneValid and no further memory request. faultLevel is 0 for a first-level fault and 1 for a second-level fault.
- R8: doneValid or faultValid rises on the cycle after the final response is taken and lasts exactly one cycle, after which the walker is idle again.
- R9: walkReady is 1 only while idle. A walkReq raised during a walk changes neither the addresses of that walk nor starts another walk.
- R10: memRspValid while no response is awaited has no effect: no request, completion or fault follows.
- R11: A pulse on rootWr loads rootPpn into the root register, and later walks index from the new root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWr | input | 1 | Load strobe for the root table register |
| rootPpn | input | 20 | Page number of the root table |
| walkReq | input | 1 | Start a walk (taken only when walkReady) |
| walkVa | input | 32 | Virtual address that missed |
| walkReady | output | 1 | Walker idle and able to accept a walk |
| memReqValid | output | 1 | One-cycle memory read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Page table entry read from memory |
| doneValid | output | 1 | Translation found (one cycle) |
| donePpn | output | 20 | Physical page number of the translation |
| doneRead | output | 1 | Read permission of the final entry |
| doneWrite | output | 1 | Write permission of the final entry |
| doneDirty | output | 1 | Dirty bit of the final entry |
| doneLarge | output | 1 | Translation came from a first-level large page |
| faultValid | output | 1 | Walk aborted with a page fault (one cycle) |
| faultLevel | output | 1 | Table level that faulted: 0 first, 1 second |

## Verification
The bench builds the walker with its default geometry: 10-bit indices at both levels, a 12-bit offset and 32-bit entries. Under that geometry the largest index, 1023, places an entry in the last word of a 4 KB table. The large-page result splices the first-level page number onto the virtual address exactly at the 10-bit boundary, so an off-by-one in either field shows up. Response latencies from zero to three cycles, a root change between walks, and start requests held high during a busy walk cover the timing and acceptance rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry bit positions the walker decodes.
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_LEAF    = 1;
  localparam int unsigned PTE_READ    = 2;
  localparam int unsigned PTE_WRITE   = 3;
  localparam int unsigned PTE_DIRTY   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic grabVa;      // latch the missing virtual address
    logic useL2Base;   // drive the second-level entry address
    logic keepNext;    // store next-table page number
    logic keepLeafL1;  // store large-page result
    logic keepLeafL2;  // store small-page result
    logic markL1Fault; // record fault at first level
    logic markL2Fault; // record fault at second level
  } walk_strobe_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [PA_W-OFS_W-1:0] tableBase,
  input  logic [IDX_W-1:0]      index,
  output logic [PA_W-1:0]       entryAddr
);
  localparam int unsigned ENTRY_SHIFT = 2;

  always_comb begin
    entryAddr = {tableBase, {OFS_W{1'b0}}} + PA_W'({index, {ENTRY_SHIFT{1'b0}}});
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         walkReq,
  input  logic         memRspValid,
  input  logic         rspPresent,
  input  logic         rspLeaf,
  output walk_strobe_t strb,
  output logic         walkReady,
  output logic         memReqValid,
  output logic         doneValid,
  output logic         faultValid
);
  walk_state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (walkReq) begin
          strb.grabVa = 1'b1;
          stateNxt    = ST_L1_REQ;
        end
      end
      ST_L1_REQ: stateNxt = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent) begin
            strb.markL1Fault = 1'b1;
            stateNxt         = ST_FAULT;
          end else if (rspLeaf) begin
            strb.keepLeafL1 = 1'b1;
            stateNxt        = ST_DONE;
          end else begin
            strb.keepNext = 1'b1;
            stateNxt      = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ: begin
        strb.useL2Base = 1'b1;
        stateNxt       = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent) begin
            strb.markL2Fault = 1'b1;
            stateNxt         = ST_FAULT;
          end else begin
            strb.keepLeafL2 = 1'b1;
            stateNxt        = ST_DONE;
          end
        end
      end
      ST_DONE:  stateNxt = ST_IDLE;
      ST_FAULT: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    walkReady   = (state == ST_IDLE);
    memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    doneValid   = (state == ST_DONE);
    faultValid  = (state == ST_FAULT);
  end
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  walk_strobe_t                strb,
  input  logic [L1_W+L2_W+OFS_W-1:0]  walkVa,
  input  logic                        rootWr,
  input  logic [PA_W-OFS_W-1:0]       rootPpn,
  input  logic [PTE_W-1:0]            memRspData,
  output logic [PA_W-1:0]             memReqAddr,
  output logic                        rspPresent,
  output logic                        rspLeaf,
  output logic [PA_W-OFS_W-1:0]       donePpn,
  output logic                        doneRead,
  output logic                        doneWrite,
  output logic                        doneDirty,
  output logic                        doneLarge,
  output logic                        faultLevel
);
  localparam int unsigned VA_W  = L1_W + L2_W + OFS_W;
  localparam int unsigned PPN_W = PA_W - OFS_W;
  localparam int unsigned HI_W  = PPN_W - L2_W;
  localparam int unsigned IX_W  = L1_W + L2_W;

  logic [PPN_W-1:0] rootReg, nextTbl, resPpn, rspPpn;
  logic [IX_W-1:0]  vpnReg;
  logic [L1_W-1:0]  l1Idx;
  logic [L2_W-1:0]  l2Idx;
  logic [PA_W-1:0]  l1EntryAddr, l2EntryAddr;
  logic [2:0]       resPerm;
  logic             resLarge, faultLvl;
  logic             unusedBits;

  assign rspPpn     = memRspData[PTE_W-1 -: PPN_W];
  assign rspPresent = memRspData[PTE_PRESENT];
  assign rspLeaf    = memRspData[PTE_LEAF];
  assign l1Idx      = vpnReg[IX_W-1 -: L1_W];
  assign l2Idx      = vpnReg[L2_W-1:0];
  assign unusedBits = ^{memRspData[PTE_W-PPN_W-1:PTE_DIRTY+1], walkVa[OFS_W-1:0]};

  ptw_entry_addr #(.PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(L1_W)) u_l1Addr (
    .tableBase(rootReg), .index(l1Idx), .entryAddr(l1EntryAddr)
  );

  ptw_entry_addr #(.PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(L2_W)) u_l2Addr (
    .tableBase(nextTbl), .index(l2Idx), .entryAddr(l2EntryAddr)
  );

  assign memReqAddr = strb.useL2Base ? l2EntryAddr : l1EntryAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootReg  <= '0;
      vpnReg   <= '0;
      nextTbl  <= '0;
      resPpn   <= '0;
      resPerm  <= '0;
      resLarge <= 1'b0;
      faultLvl <= 1'b0;
    end else begin
      if (rootWr)      rootReg <= rootPpn;
      if (strb.grabVa) vpnReg  <= walkVa[VA_W-1:OFS_W];
      if (strb.keepNext) nextTbl <= rspPpn;
      if (strb.keepLeafL1) begin
        resPpn   <= {rspPpn[PPN_W-1 -: HI_W], l2Idx};
        resPerm  <= memRspData[PTE_DIRTY:PTE_READ];
        resLarge <= 1'b1;
      end
      if (strb.keepLeafL2) begin
        resPpn   <= rspPpn;
        resPerm  <= memRspData[PTE_DIRTY:PTE_READ];
        resLarge <= 1'b0;
      end
      if (strb.markL1Fault) faultLvl <= 1'b0;
      if (strb.markL2Fault) faultLvl <= 1'b1;
    end
  end

  assign donePpn    = resPpn;
  assign doneRead   = resPerm[0];
  assign doneWrite  = resPerm[1];
  assign doneDirty  = resPerm[2];
  assign doneLarge  = resLarge;
  assign faultLevel = faultLvl;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rootWr,
  input  logic [PA_W-OFS_W-1:0]      rootPpn,
  input  logic                       walkReq,
  input  logic [L1_W+L2_W+OFS_W-1:0] walkVa,
  output logic                       walkReady,
  output logic                       memReqValid,
  output logic [PA_W-1:0]            memReqAddr,
  input  logic                       memRspValid,
  input  logic [PTE_W-1:0]           memRspData,
  output logic                       doneValid,
  output logic [PA_W-OFS_W-1:0]      donePpn,
  output logic                       doneRead,
  output logic                       doneWrite,
  output logic                       doneDirty,
  output logic                       doneLarge,
  output logic                       faultValid,
  output logic                       faultLevel
);
  walk_strobe_t strb;
  logic         rspPresent, rspLeaf;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .memRspValid(memRspValid),
    .rspPresent(rspPresent), .rspLeaf(rspLeaf), .strb(strb),
    .walkReady(walkReady), .memReqValid(memReqValid),
    .doneValid(doneValid), .faultValid(faultValid)
  );

  ptw_dpath #(.PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .OFS_W(OFS_W), .PTE_W(PTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .walkVa(walkVa), .rootWr(rootWr),
    .rootPpn(rootPpn), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .rspPresent(rspPresent), .rspLeaf(rspLeaf), .donePpn(donePpn),
    .doneRead(doneRead), .doneWrite(doneWrite), .doneDirty(doneDirty),
    .doneLarge(doneLarge), .faultLevel(faultLevel)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic clk,
  input logic rstN,
  input logic walkReq,
  input logic walkReady,
  input logic memReqValid,
  input logic memRspValid,
  input logic doneValid,
  input logic faultValid
);
  // R2
  accept_issues_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkReady |=> memReqValid);

  // R2
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R7
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && walkReady);

  // R8
  fault_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid && walkReady);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || doneValid || faultValid) |-> !walkReady);

  // R10
  idle_rsp_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReady && memRspValid && !walkReq |=> walkReady && !memReqValid);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .walkReq(walkReq), .walkReady(walkReady),
  .memReqValid(memReqValid), .memRspValid(memRspValid),
  .doneValid(doneValid), .faultValid(faultValid)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootWr = 1'b0;
  logic [19:0] rootPpn = '0;
  logic        walkReq = 1'b0;
  logic [31:0] walkVa = '0;
  logic        walkReady, memReqValid, memRspValid = 1'b0;
  logic [31:0] memReqAddr, memRspData = '0;
  logic        doneValid, doneRead, doneWrite, doneDirty, doneLarge;
  logic        faultValid, faultLevel;
  logic [19:0] donePpn;

  int vecCount = 0;
  int missCount = 0;
  logic [19:0] rootNow = '0;
  logic [31:0] pmem [logic [31:0]];

  always #10 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rstN(rstN), .rootWr(rootWr), .rootPpn(rootPpn),
    .walkReq(walkReq), .walkVa(walkVa), .walkReady(walkReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePpn(donePpn), .doneRead(doneRead),
    .doneWrite(doneWrite), .doneDirty(doneDirty), .doneLarge(doneLarge),
    .faultValid(faultValid), .faultLevel(faultLevel)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkPte(input logic [19:0] pn, input bit leaf,
                                        input bit r, input bit w, input bit d,
                                        input bit present);
    return {pn, 7'h0, d, w, r, leaf, present};
  endfunction

  task automatic quiet(input string req);
    check(req, "memReqValid idle", 32'(memReqValid), 0);
    check(req, "doneValid quiet",  32'(doneValid), 0);
    check(req, "faultValid quiet", 32'(faultValid), 0);
  endtask

  task automatic setRoot(input logic [19:0] r);
    @(negedge clk); rootWr = 1'b1; rootPpn = r;
    @(negedge clk); rootWr = 1'b0; rootNow = r;
  endtask

  task automatic runWalk(input logic [31:0] va, input int latA, input int latB,
                         input bit poke, input logic [31:0] pokeVa);
    logic [31:0] a1, e1, a2, e2, fin;
    logic [19:0] expPpn;
    bit expFault, expLvl, expLarge;
    int nLvl;
    a1 = {rootNow, 12'h0} + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    a2 = '0; e2 = '0;
    expFault = 0; expLvl = 0; expLarge = 0; expPpn = '0; fin = e1;
    if (!e1[0]) begin
      nLvl = 1; expFault = 1; expLvl = 0;
    end else if (e1[1]) begin
      nLvl = 1; expLarge = 1; expPpn = {e1[31:22], va[21:12]};
    end else begin
      nLvl = 2;
      a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      e2 = rd(a2); fin = e2;
      if (!e2[0]) begin expFault = 1; expLvl = 1; end
      else expPpn = e2[31:12];
    end

    @(negedge clk);
    check("R9", "walkReady before start", 32'(walkReady), 1);
    walkReq = 1'b1; walkVa = va;
    @(negedge clk);
    if (poke) walkVa = pokeVa; else walkReq = 1'b0;
    for (int lv = 0; lv < nLvl; lv++) begin
      if (lv == 0) begin
        check("R2", "L1 request", 32'(memReqValid), 1);
        check("R2", "L1 address", memReqAddr, a1);
      end else begin
        check("R3", "L2 request", 32'(memReqValid), 1);
        check("R3", "L2 address", memReqAddr, a2);
      end
      check("R9", "walkReady busy", 32'(walkReady), 0);
      for (int k = 0; k < ((lv == 0) ? latA : latB); k++) begin
        @(negedge clk);
        quiet("R9");
        check("R9", "walkReady waiting", 32'(walkReady), 0);
      end
      @(negedge clk);
      quiet("R8");
      memRspValid = 1'b1;
      memRspData  = (lv == 0) ? e1 : e2;
      if (lv == nLvl - 1) walkReq = 1'b0;
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = 32'hDEAD_BEEF;
    end
    if (expFault) begin
      check("R7", "faultValid", 32'(faultValid), 1);
      check("R7", "doneValid on fault", 32'(doneValid), 0);
      check("R7", "faultLevel", 32'(faultLevel), 32'(expLvl));
      check("R7", "no request on fault", 32'(memReqValid), 0);
    end else begin
      check("R8", "doneValid", 32'(doneValid), 1);
      check("R8", "faultValid on done", 32'(faultValid), 0);
      check(expLarge ? "R4" : "R5", "donePpn", 32'(donePpn), 32'(expPpn));
      check(expLarge ? "R4" : "R5", "doneLarge", 32'(doneLarge), 32'(expLarge));
      check("R6", "doneRead",  32'(doneRead),  32'(fin[2]));
      check("R6", "doneWrite", 32'(doneWrite), 32'(fin[3]));
      check("R6", "doneDirty", 32'(doneDirty), 32'(fin[4]));
    end
    @(negedge clk);
    check("R8", "walkReady after end", 32'(walkReady), 1);
    quiet("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    // table contents
    pmem[32'h0001_000C] = mkPte(20'h00020, 0, 1, 1, 0, 1);
    pmem[32'h0002_0014] = mkPte(20'hABCDE, 1, 1, 0, 1, 1);
    pmem[32'h0002_0018] = mkPte(20'h00777, 0, 1, 1, 0, 0);
    pmem[32'h0001_001C] = mkPte(20'h12345, 1, 1, 1, 0, 1);
    pmem[32'h0001_0FFC] = mkPte(20'h00030, 0, 0, 0, 0, 1);
    pmem[32'h0003_0FFC] = mkPte(20'hFFFFF, 0, 1, 1, 1, 1);
    pmem[32'h0001_0000] = mkPte(20'hFFC00, 1, 0, 0, 1, 1);
    pmem[32'h0004_000C] = mkPte(20'h5A5A5, 1, 0, 1, 0, 1);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "walkReady after reset", 32'(walkReady), 1);
    quiet("R1");

    setRoot(20'h00010);                                           // R11
    runWalk({10'd3, 10'd5, 12'hABC}, 0, 0, 0, 0);                 // R3 R5 small page
    runWalk({10'd7, 10'h155, 12'h000}, 2, 0, 0, 0);               // R4 large page
    runWalk({10'd9, 10'd1, 12'h123}, 1, 0, 0, 0);                 // R7 level-1 fault
    runWalk({10'd3, 10'd6, 12'h000}, 0, 3, 0, 0);                 // R7 level-2 fault
    runWalk(32'hFFFF_FFFF, 3, 2, 0, 0);                           // max indices
    runWalk(32'h0000_0000, 0, 0, 0, 0);                           // zero indices, large
    runWalk({10'd3, 10'd5, 12'h001}, 1, 2, 1, {10'd9, 22'h0});    // R9 poke while busy

    // R10 stray response while idle
    @(negedge clk);
    memRspValid = 1'b1; memRspData = mkPte(20'h11111, 1, 1, 1, 1, 1);
    @(negedge clk);
    memRspValid = 1'b0;
    quiet("R10");
    check("R10", "walkReady after stray rsp", 32'(walkReady), 1);
    @(negedge clk);
    quiet("R10");

    setRoot(20'h00040);                                           // R11 new root
    runWalk({10'd3, 10'd5, 12'h000}, 3, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule